// File: doc/BRIEF.md
# Debug trace message serializer

This block turns watchpoint-hit and error events from an on-chip debug unit into fixed-format trace messages. It sends them off chip over a two-bit message data port. The port has a framing pin and a message clock. Each event becomes one message word:

- A watchpoint message carries a type code, a source field and the number of the watchpoint that fired.
- An error message carries a type code, a source field and a five-bit error code.

Message words wait in a small first-in first-out queue. A shifter drains the queue two bits per message clock, least significant bit first.

An event may arrive when the queue has no room. The event is then dropped, and the block remembers that something was lost. When a slot frees up, the block inserts an overrun error message into the queue ahead of any newer message. The code in that message tells the debugger whether only watchpoint messages were lost or whether error messages were lost as well.

A stall output can hold off the event source while the queue is nearly full. This reduces overruns, but it cannot rule them out.

Top module: `trace_msg_serializer`

## Requirements
- R1: Out of reset, and on every idle beat, `tx_frame` is 1 and `tx_data` is 00.
- R2: `tx_clk` toggles on every `clk` cycle, and one beat lasts one `tx_clk` period. `tx_data` and `tx_frame` change only at the `clk` edge where `tx_clk` falls. Message bit 2k appears on `tx_data[0]` and bit 2k+1 appears on `tx_data[1]` in beat k.
- R3: `tx_frame` is 0 on every beat of a message except the last beat, where it is 1. At least one idle beat separates two messages.
- R4: An error message is 15 bits, sent in 8 beats:
  - bits 5:0 hold 8;
  - bits 9:6 hold `SRC_ID` (default 0);
  - bits 14:10 hold the error code;
  - bit 15 is a zero pad in `tx_data[1]` of the eighth beat.
- R5: A watchpoint message is 10+`WPW` bits, sent in 7 beats by default:
  - bits 5:0 hold 15;
  - bits 9:6 hold `SRC_ID`;
  - bits 9+`WPW`:10 hold `wp_num`.
- R6: Messages leave in the order their events were sampled, and the queue holds up to `DEPTH` (4) messages. When `err_hit` and `wp_hit` are sampled in the same cycle, the error message goes first.
- R7: A `wp_hit` that finds the queue full is dropped. When space next frees, an error message with code 6 is queued ahead of any later message.
- R8: If any error event was dropped since the last overrun report, that report carries code 8 instead of 6.
- R9: `stall_out` is 1 when `stall_en` is 1 and at least `DEPTH`-1 messages are queued. `stall_out` is 0 whenever `stall_en` is 0.
- R10: The first beat of a message drives `tx_frame` low within 2 `clk` edges of the edge that samples its event, provided the queue is empty and the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_hit | input | 1 | Watchpoint fired this cycle |
| wp_num | input | WPW | Number of the watchpoint that fired |
| err_hit | input | 1 | Error event this cycle |
| err_code | input | 5 | Error code of the error event |
| stall_en | input | 1 | Enables the stall request |
| stall_out | output | 1 | Asks the event source to hold off |
| tx_clk | output | 1 | Message clock, half the `clk` rate |
| tx_data | output | 2 | Message data, two bits per beat |
| tx_frame | output | 1 | Framing pin: idle high, low within a message, high on its last beat |

## Verification
The first beat of a message from an idle block is due one or two `clk` edges after the edge that samples the event; the exact count depends on the `tx_clk` phase. Every later beat follows two cycles after the one before it. The bench therefore samples the port only at falling `clk` edges while `tx_clk` is high, which is the middle of each beat. The latency check allows exactly three such falling edges. Overrun sequences are driven back to back, so the queue fills by the fifth event whichever phase the first pop falls in. The bench then waits a fixed 20 cycles per expected message plus margin before it compares the decoded message list.

// File: rtl/trace_msg_serializer.sv
`timescale 1ns/1ps
module trace_msg_serializer #(
  parameter int DEPTH = 4,
  parameter int WPW = 4,
  parameter logic [3:0] SRC_ID = 4'd0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wp_hit,
  input  logic [WPW-1:0] wp_num,
  input  logic           err_hit,
  input  logic [4:0]     err_code,
  input  logic           stall_en,
  output logic           stall_out,
  output logic           tx_clk,
  output logic [1:0]     tx_data,
  output logic           tx_frame
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (WPW > 5) ? WPW : 5;
  localparam int WP_BEATS = (10 + WPW + 1) / 2;
  localparam int ERR_BEATS = 8;
  localparam int MAXB = (WP_BEATS > ERR_BEATS) ? WP_BEATS : ERR_BEATS;
  localparam int SHW = 2 * MAXB;
  localparam int BW = $clog2(MAXB + 1);

  logic [PW:0]    mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  count;
  logic           lost_wp, lost_other;
  logic           ph, gap, pop;
  logic [SHW-1:0] sh, ld;
  logic [BW-1:0]  rem;
  logic [PW:0]    head;
  int             ld_beats;

  logic [PW:0] cd [3];
  logic        cv [3];
  logic [PW:0] wd [3];
  logic [1:0]  nwr;
  logic        rep_taken, drop_err, drop_wp;
  int          free;

  always_comb begin
    cv[0] = lost_wp | lost_other;
    cd[0] = {1'b1, PW'(lost_other ? 5'd8 : 5'd6)};
    cv[1] = err_hit;
    cd[1] = {1'b1, PW'(err_code)};
    cv[2] = wp_hit;
    cd[2] = {1'b0, PW'(wp_num)};
    free = DEPTH - int'(count);
    nwr = 2'd0;
    rep_taken = 1'b0;
    drop_err = 1'b0;
    drop_wp = 1'b0;
    for (int i = 0; i < 3; i++) wd[i] = '0;
    for (int i = 0; i < 3; i++) begin
      if (cv[i]) begin
        if (int'(nwr) < free) begin
          wd[nwr] = cd[i];
          nwr = nwr + 2'd1;
          if (i == 0) rep_taken = 1'b1;
        end else if (i == 1) drop_err = 1'b1;
        else if (i == 2) drop_wp = 1'b1;
      end
    end
  end

  assign head = mem[rd_ptr];
  assign ld = head[PW] ? SHW'({head[4:0], SRC_ID, 6'd8})
                       : SHW'({head[WPW-1:0], SRC_ID, 6'd15});
  assign ld_beats = head[PW] ? ERR_BEATS : WP_BEATS;
  assign pop = ph && (rem == '0) && !gap && (count != '0);
  assign tx_clk = ph;
  assign stall_out = stall_en && (count >= CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      if (i < int'(nwr)) mem[wr_ptr + AW'(i)] <= wd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count <= '0;
      lost_wp <= 1'b0;
      lost_other <= 1'b0;
      ph <= 1'b0;
      gap <= 1'b0;
      sh <= '0;
      rem <= '0;
      tx_data <= 2'b00;
      tx_frame <= 1'b1;
    end else begin
      ph <= ~ph;
      wr_ptr <= wr_ptr + AW'(nwr);
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(nwr) - CW'(pop);
      if (rep_taken) begin
        lost_wp <= drop_wp;
        lost_other <= drop_err;
      end else begin
        lost_wp <= lost_wp | drop_wp;
        lost_other <= lost_other | drop_err;
      end
      if (ph) begin
        if (rem != '0) begin
          tx_data <= sh[1:0];
          sh <= sh >> 2;
          tx_frame <= (rem == BW'(1));
          gap <= (rem == BW'(1));
          rem <= rem - BW'(1);
        end else if (pop) begin
          tx_data <= ld[1:0];
          sh <= ld >> 2;
          tx_frame <= 1'b0;
          rem <= BW'(ld_beats - 1);
          gap <= 1'b0;
        end else begin
          tx_data <= 2'b00;
          tx_frame <= 1'b1;
          gap <= 1'b0;
        end
      end
    end
  end
endmodule

module trace_msg_serializer_chk #(
  parameter int DEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tx_clk,
  input logic [1:0]                   tx_data,
  input logic                         tx_frame,
  input logic                         stall_en,
  input logic                         stall_out,
  input logic [$clog2(DEPTH+1)-1:0]   count,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_ptr,
  input logic                         gap,
  input logic                         pop
);
  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk |-> $stable({tx_data, tx_frame}));
  assert_gap_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clk && gap) |=> (tx_frame && tx_data == 2'b00));
  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == ($clog2(DEPTH+1))'(DEPTH) && !pop) |=> $stable(wr_ptr));
  assert_stall_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_en |-> !stall_out);
  assert_stall_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && count == ($clog2(DEPTH+1))'(DEPTH)) |-> stall_out);
endmodule

bind trace_msg_serializer trace_msg_serializer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk), .tx_data(tx_data),
  .tx_frame(tx_frame), .stall_en(stall_en), .stall_out(stall_out),
  .count(count), .wr_ptr(wr_ptr), .gap(gap), .pop(pop));

// File: tb/trace_msg_serializer_bench.sv
`timescale 1ns/1ps
module trace_msg_serializer_bench;
  localparam int WPW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wp_hit = 1'b0, err_hit = 1'b0, stall_en = 1'b0;
  logic [WPW-1:0] wp_num = '0;
  logic [4:0] err_code = '0;
  logic stall_out, tx_clk, tx_frame;
  logic [1:0] tx_data;

  trace_msg_serializer u_trace_msg_serializer (
    .clk(clk), .rst_n(rst_n), .wp_hit(wp_hit), .wp_num(wp_num),
    .err_hit(err_hit), .err_code(err_code), .stall_en(stall_en),
    .stall_out(stall_out), .tx_clk(tx_clk), .tx_data(tx_data), .tx_frame(tx_frame));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int rx_n = 0, idle_err = 0, gap_err = 0;
  logic [31:0] rx_word [64];
  int rx_nb [64];
  logic in_frame = 1'b0, prev_last = 1'b0;
  logic [31:0] cur;
  int nb;

  always @(negedge clk) begin
    if (rst_n && tx_clk) begin
      if (!in_frame) begin
        if (!tx_frame) begin
          if (prev_last) gap_err++;
          in_frame = 1'b1;
          cur = '0;
          cur[1:0] = tx_data;
          nb = 1;
        end else if (tx_data != 2'b00) idle_err++;
        prev_last = 1'b0;
      end else begin
        if (nb < 16) cur[2*nb +: 2] = tx_data;
        nb++;
        if (tx_frame) begin
          in_frame = 1'b0;
          prev_last = 1'b1;
          if (rx_n < 64) begin
            rx_word[rx_n] = cur;
            rx_nb[rx_n] = nb;
          end
          rx_n++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] err_word(input int code);
    return 32'(code * 1024 + 8);
  endfunction
  function automatic logic [31:0] wp_word(input int num);
    return 32'(num * 1024 + 15);
  endfunction

  task automatic chk_msg(input string tag, input int idx, input bit is_err, input int val);
    chk({tag, " present"}, 32'(idx < rx_n), 32'd1);
    if (idx < rx_n) begin
      chk({tag, " word"}, rx_word[idx], is_err ? err_word(val) : wp_word(val));
      chk({tag, " beats"}, 32'(rx_nb[idx]), is_err ? 32'd8 : 32'd7);
    end
  endtask

  task automatic drain(input int n);
    repeat (20 * n + 40) @(negedge clk);
  endtask

  task automatic pulse(input bit w, input int num, input bit e, input int code);
    wp_hit = w; wp_num = WPW'(num); err_hit = e; err_code = 5'(code);
    @(negedge clk);
    wp_hit = 1'b0; err_hit = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset frame", 32'(tx_frame), 32'd1);
    chk("R1 reset data", 32'(tx_data), 32'd0);
    chk("R9 reset stall", 32'(stall_out), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int n = 0; n < 16; n++) begin
      rx_n = 0;
      pulse(1, n, 0, 0);
      drain(1);
      chk("R5 wp sweep count", 32'(rx_n), 32'd1);
      chk_msg("R5 wp sweep", 0, 0, n);
    end
    for (int c = 0; c < 32; c++) begin
      rx_n = 0;
      pulse(0, 0, 1, c);
      drain(1);
      chk("R4 err sweep count", 32'(rx_n), 32'd1);
      chk_msg("R4 err sweep pad R2", 0, 1, c);
    end

    begin
      int waited = 0;
      wp_hit = 1'b1; wp_num = 4'd5;
      @(negedge clk);
      wp_hit = 1'b0;
      waited = 1;
      while (tx_frame && waited < 3) begin
        @(negedge clk);
        waited++;
      end
      chk("R10 first beat latency", 32'(tx_frame), 32'd0);
      drain(1);
    end

    rx_n = 0;
    pulse(1, 3, 0, 0); pulse(1, 9, 0, 0); pulse(1, 12, 0, 0);
    drain(3);
    chk("R6 order count", 32'(rx_n), 32'd3);
    chk_msg("R6 order 0", 0, 0, 3);
    chk_msg("R6 order 1", 1, 0, 9);
    chk_msg("R6 order 2", 2, 0, 12);

    rx_n = 0;
    pulse(1, 11, 1, 21);
    drain(2);
    chk("R6 same cycle count", 32'(rx_n), 32'd2);
    chk_msg("R6 same cycle err first", 0, 1, 21);
    chk_msg("R6 same cycle wp second", 1, 0, 11);

    rx_n = 0;
    stall_en = 1'b1;
    chk("R9 stall low when empty", 32'(stall_out), 32'd0);
    for (int i = 0; i < 10; i++) begin
      pulse(1, i, 0, 0);
      if (i == 6) begin
        chk("R9 stall high when full", 32'(stall_out), 32'd1);
        stall_en = 1'b0;
        #0.5;
        chk("R9 stall off when disabled", 32'(stall_out), 32'd0);
        stall_en = 1'b1;
      end
    end
    stall_en = 1'b0;
    drain(6);
    chk("R7 overrun count", 32'(rx_n), 32'd6);
    for (int i = 0; i < 5; i++) chk_msg("R7 kept wp", i, 0, i);
    chk_msg("R7 overrun code 6", 5, 1, 6);

    rx_n = 0;
    for (int i = 1; i <= 6; i++) pulse(0, 0, 1, i);
    drain(6);
    chk("R8 err loss count", 32'(rx_n), 32'd6);
    for (int i = 0; i < 5; i++) chk_msg("R8 kept err", i, 1, i + 1);
    chk_msg("R8 overrun code 8", 5, 1, 8);

    rx_n = 0;
    for (int i = 0; i < 5; i++) pulse(1, i + 2, 0, 0);
    pulse(0, 0, 1, 7);
    drain(6);
    chk("R8 mixed loss count", 32'(rx_n), 32'd6);
    for (int i = 0; i < 5; i++) chk_msg("R8 mixed kept wp", i, 0, i + 2);
    chk_msg("R8 mixed overrun code 8", 5, 1, 8);

    chk("R1 idle beats carry 00", 32'(idle_err), 32'd0);
    chk("R3 idle beat between messages", 32'(gap_err), 32'd0);
    chk("R1 final idle frame", 32'(tx_frame), 32'd1);
    finish_run();
  end
endmodule